// File: doc/BRIEF.md
# Multiply-Accumulate Unit with HI/LO Accumulator

This block multiplies the low 32 bits of two 64-bit source operands and merges the 64-bit product into an accumulator. The accumulator does not live in its own register. Its upper half sits in the low word of a 64-bit HI register, and its lower half sits in the low word of a 64-bit LO register. Each operation is chosen by a 6-bit function code and a 5-bit sub-operation code. The choice sets four things: whether the product is signed or unsigned, how the product combines with the accumulator, whether a destination value is produced, and which half of the accumulator that value comes from.

The combine modes are:
- clear-then-add (0+P)
- clear-then-negate (0−P)
- accumulate (ACC+P)
- subtract-accumulate (ACC−P)

There is also a doubleword accumulate. It adds the signed product to the whole 64-bit LO register and leaves HI alone. The destination value is the selected 32-bit half of the updated accumulator, sign-extended to 64 bits.

A caller pulses `start` for one cycle with the operation and operands. One cycle later `res_valid` is high. HI, LO and the destination output all change on that same cycle. The block is a single-cycle product stage followed by one register stage.

Top module: `mac_hilo_unit`

## Requirements
- R1: After synchronous reset, `hi_q`, `lo_q` and `dst_data` are zero, and `res_valid` and `dst_valid` are low.
- R2: The accumulator value is {HI[31:0], LO[31:0]}. An accumulator update writes only HI[31:0] and LO[31:0]. HI[63:32] and LO[63:32] keep their values.
- R3: Accumulator arithmetic wraps modulo 2^64 and raises no flag.
- R4: The operands are `src_a[31:0]` and `src_b[31:0]`, and bits 63:32 of the sources have no effect. Signed forms treat the operands as two's complement. Unsigned forms treat them as unsigned. Both give a 64-bit product P.
- R5: Clear-then-add (ACC = P) is selected by function code 6'b101000 with these sub-ops:
  - 5'b00100: signed, low half
  - 5'b00101: unsigned, low half
  - 5'b01100: signed, high half
  - 5'b01101: unsigned, high half
- R6: Clear-then-negate (ACC = 0−P) is selected by sub-op 5'b00011 (low half) or 5'b01011 (high half). Function code 6'b011000 gives the signed form and 6'b011001 the unsigned form.
- R7: Accumulate (ACC = ACC+P) is selected by function code 6'b101000 with these sub-ops:
  - 5'b00010: signed, low half
  - 5'b00011: unsigned, low half
  - 5'b01010: signed, high half
  - 5'b01011: unsigned, high half
- R8: Subtract-accumulate (ACC = ACC−P) is selected by sub-op 5'b00111 (low half) or 5'b01111 (high half). Function code 6'b011000 gives the signed form and 6'b011001 the unsigned form.
- R9: Function code 6'b101000 with sub-op 5'b00000 performs ACC = ACC + signed P. It never raises `dst_valid`.
- R10: Function code 6'b101001 with sub-op 5'b00000 sets LO = LO + signed P over all 64 bits. HI is unchanged and `dst_valid` is never raised.
- R11: For an operation from R5 to R8 with `dst_wr_req` high, `dst_valid` is high and `dst_data` holds the selected half of the updated accumulator, sign-extended from bit 31. In every other case `dst_valid` is low.
- R12: `res_valid` is high exactly in the cycle after a `start` cycle. Updates to HI, LO and the destination appear in that same cycle. With `start` low, HI and LO do not change.
- R13: A started operation whose code combination is not listed in R5 to R10 leaves HI and LO unchanged and does not raise `dst_valid`. `res_valid` still pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle operation strobe |
| func_code | input | 6 | Function code of the operation |
| sub_op | input | 5 | Sub-operation code |
| dst_wr_req | input | 1 | Request to produce a destination value |
| src_a | input | 64 | First source operand (low 32 bits used) |
| src_b | input | 64 | Second source operand (low 32 bits used) |
| hi_q | output | 64 | HI register |
| lo_q | output | 64 | LO register |
| dst_data | output | 64 | Sign-extended destination value |
| dst_valid | output | 1 | Destination value valid |
| res_valid | output | 1 | Operation completed this cycle |

## Verification
The following are checked on every cycle:
- `res_valid` tracks `start` with one cycle of delay.
- The upper words of HI and LO are held, and HI is held across doubleword accumulates.
- Illegal codes change nothing.
- A destination value is always the sign-extended low word of HI or of LO.
- Each of the four combine modes relates the new accumulator to the previous accumulator and product.

Only the directed scenarios show that the code decoding and arithmetic meet the requirements, which the assertions cannot, because they reuse the block's own decode and product. These scenarios cover:
- the exact product values for signed and unsigned operands with dirty upper bits
- wrap-around through 2^64
- the suppression of the destination when it was not requested

// File: rtl/mac_pkg.sv
`timescale 1ns/1ps
package mac_pkg;

    // Operation group codes seen on func_code
    localparam logic [5:0] FN_MULACC  = 6'b101000;
    localparam logic [5:0] FN_DWACC   = 6'b101001;
    localparam logic [5:0] FN_NEG_SGN = 6'b011000;
    localparam logic [5:0] FN_NEG_UNS = 6'b011001;

    // How the product is merged into the accumulator
    typedef enum logic [2:0] {
        CMB_ZERO_ADD = 3'd0,
        CMB_ZERO_SUB = 3'd1,
        CMB_ACC_ADD  = 3'd2,
        CMB_ACC_SUB  = 3'd3,
        CMB_LO_ADD   = 3'd4
    } combine_e;

    // Decoded operation carried down the datapath
    typedef struct packed {
        logic     legal;
        combine_e mode;
        logic     uns;
        logic     hi_half;
        logic     has_dst;
    } mac_op_t;

    // Sub-op bits [2:1] inside the multiply/accumulate group
    localparam logic [1:0] SUBGRP_CLEAR = 2'b10;
    localparam logic [1:0] SUBGRP_ACCUM = 2'b01;

endpackage

// File: rtl/mac_decode.sv
`timescale 1ns/1ps
module mac_decode
    import mac_pkg::*;
(
    input  logic [5:0] func_i,
    input  logic [4:0] sub_i,
    output mac_op_t    op_o
);

    always_comb begin
        op_o         = '0;
        op_o.mode    = CMB_ACC_ADD;
        unique case (func_i)
            FN_MULACC: begin
                if (sub_i == 5'b00000) begin
                    // plain accumulate, signed, no result register
                    op_o.legal = 1'b1;
                    op_o.mode  = CMB_ACC_ADD;
                end else if (!sub_i[4] && sub_i[2:1] == SUBGRP_CLEAR) begin
                    op_o.legal   = 1'b1;
                    op_o.mode    = CMB_ZERO_ADD;
                    op_o.uns     = sub_i[0];
                    op_o.hi_half = sub_i[3];
                    op_o.has_dst = 1'b1;
                end else if (!sub_i[4] && sub_i[2:1] == SUBGRP_ACCUM) begin
                    op_o.legal   = 1'b1;
                    op_o.mode    = CMB_ACC_ADD;
                    op_o.uns     = sub_i[0];
                    op_o.hi_half = sub_i[3];
                    op_o.has_dst = 1'b1;
                end
            end
            FN_DWACC: begin
                if (sub_i == 5'b00000) begin
                    op_o.legal = 1'b1;
                    op_o.mode  = CMB_LO_ADD;
                end
            end
            FN_NEG_SGN, FN_NEG_UNS: begin
                if (!sub_i[4] && sub_i[1:0] == 2'b11) begin
                    op_o.legal   = 1'b1;
                    op_o.mode    = sub_i[2] ? CMB_ACC_SUB : CMB_ZERO_SUB;
                    op_o.uns     = func_i[0];
                    op_o.hi_half = sub_i[3];
                    op_o.has_dst = 1'b1;
                end
            end
            default: op_o.legal = 1'b0;
        endcase
    end

endmodule

// File: rtl/mac_mult.sv
`timescale 1ns/1ps
module mac_mult #(
    parameter int OPW = 32,
    localparam int PW = 2 * OPW
) (
    input  logic [OPW-1:0] a_i,
    input  logic [OPW-1:0] b_i,
    input  logic           uns_i,
    output logic [PW-1:0]  prod_o
);

    logic          a_fill, b_fill;
    logic [PW-1:0] a_ext, b_ext;

    // Extending both operands to PW bits makes one truncated multiply
    // serve the signed and unsigned forms.
    assign a_fill = uns_i ? 1'b0 : a_i[OPW-1];
    assign b_fill = uns_i ? 1'b0 : b_i[OPW-1];
    assign a_ext  = {{OPW{a_fill}}, a_i};
    assign b_ext  = {{OPW{b_fill}}, b_i};
    assign prod_o = a_ext * b_ext;

endmodule

// File: rtl/mac_combine.sv
`timescale 1ns/1ps
module mac_combine
    import mac_pkg::*;
#(
    parameter int REGW = 64,
    parameter int OPW  = 32,
    localparam int ACCW = 2 * OPW
) (
    input  logic [REGW-1:0] hi_i,
    input  logic [REGW-1:0] lo_i,
    input  logic [ACCW-1:0] prod_i,
    input  mac_op_t         op_i,
    output logic [REGW-1:0] hi_nx_o,
    output logic [REGW-1:0] lo_nx_o,
    output logic [REGW-1:0] dst_nx_o
);

    logic [ACCW-1:0] acc, acc_nx;
    logic [REGW-1:0] prod_ext;
    logic [OPW-1:0]  half;

    assign acc = {hi_i[OPW-1:0], lo_i[OPW-1:0]};

    // Product widened to a full register for the LO-only accumulate
    generate
        if (REGW > ACCW) begin : g_prod_wide
            assign prod_ext = {{(REGW-ACCW){prod_i[ACCW-1]}}, prod_i};
        end else begin : g_prod_same
            assign prod_ext = prod_i[REGW-1:0];
        end
    endgenerate

    always_comb begin
        unique case (op_i.mode)
            CMB_ZERO_ADD: acc_nx = prod_i;
            CMB_ZERO_SUB: acc_nx = '0 - prod_i;
            CMB_ACC_ADD:  acc_nx = acc + prod_i;
            CMB_ACC_SUB:  acc_nx = acc - prod_i;
            default:      acc_nx = acc;
        endcase
    end

    always_comb begin
        if (op_i.mode == CMB_LO_ADD) begin
            hi_nx_o = hi_i;
            lo_nx_o = lo_i + prod_ext;
        end else begin
            hi_nx_o = {hi_i[REGW-1:OPW], acc_nx[ACCW-1:OPW]};
            lo_nx_o = {lo_i[REGW-1:OPW], acc_nx[OPW-1:0]};
        end
    end

    assign half     = op_i.hi_half ? acc_nx[ACCW-1:OPW] : acc_nx[OPW-1:0];
    assign dst_nx_o = {{(REGW-OPW){half[OPW-1]}}, half};

endmodule

// File: rtl/mac_hilo_unit.sv
`timescale 1ns/1ps
module mac_hilo_unit
    import mac_pkg::*;
#(
    parameter int REGW = 64,
    parameter int OPW  = 32,
    localparam int ACCW = 2 * OPW
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [5:0]      func_code,
    input  logic [4:0]      sub_op,
    input  logic            dst_wr_req,
    input  logic [REGW-1:0] src_a,
    input  logic [REGW-1:0] src_b,
    output logic [REGW-1:0] hi_q,
    output logic [REGW-1:0] lo_q,
    output logic [REGW-1:0] dst_data,
    output logic            dst_valid,
    output logic            res_valid
);

    mac_op_t         op;
    logic [ACCW-1:0] prod;
    logic [REGW-1:0] hi_nx, lo_nx, dst_nx;
    logic [ACCW-1:0] acc_view;
    logic            unused_src_hi;

    // Upper source bits are deliberately ignored
    assign unused_src_hi = ^{src_a[REGW-1:OPW], src_b[REGW-1:OPW]};
    assign acc_view      = {hi_q[OPW-1:0], lo_q[OPW-1:0]};

    mac_decode u_dec (
        .func_i (func_code),
        .sub_i  (sub_op),
        .op_o   (op)
    );

    mac_mult #(.OPW(OPW)) u_mul (
        .a_i    (src_a[OPW-1:0]),
        .b_i    (src_b[OPW-1:0]),
        .uns_i  (op.uns),
        .prod_o (prod)
    );

    mac_combine #(.REGW(REGW), .OPW(OPW)) u_cmb (
        .hi_i     (hi_q),
        .lo_i     (lo_q),
        .prod_i   (prod),
        .op_i     (op),
        .hi_nx_o  (hi_nx),
        .lo_nx_o  (lo_nx),
        .dst_nx_o (dst_nx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q      <= '0;
            lo_q      <= '0;
            dst_data  <= '0;
            dst_valid <= 1'b0;
            res_valid <= 1'b0;
        end else begin
            res_valid <= start;
            dst_valid <= start && op.legal && op.has_dst && dst_wr_req;
            if (start && op.legal) begin
                hi_q <= hi_nx;
                lo_q <= lo_nx;
            end
            if (start && op.legal && op.has_dst && dst_wr_req) begin
                dst_data <= dst_nx;
            end
        end
    end

    // R12: completion pulse follows every start by one cycle
    p_valid_after_start_r12: assert property (@(posedge clk) disable iff (rst)
        start |=> res_valid);
    p_no_valid_idle_r12: assert property (@(posedge clk) disable iff (rst)
        !start |=> (!res_valid && !dst_valid && $stable(hi_q) && $stable(lo_q)));

    // R2: accumulator writes never touch the upper words
    p_upper_kept_r2: assert property (@(posedge clk) disable iff (rst)
        (start && op.mode != CMB_LO_ADD) |=>
            (hi_q[REGW-1:OPW] == $past(hi_q[REGW-1:OPW]) &&
             lo_q[REGW-1:OPW] == $past(lo_q[REGW-1:OPW])));

    // R10: doubleword accumulate leaves HI alone
    p_hi_kept_dword_r10: assert property (@(posedge clk) disable iff (rst)
        (start && op.legal && op.mode == CMB_LO_ADD) |=> $stable(hi_q));

    // R13: illegal codes have no effect
    p_illegal_hold_r13: assert property (@(posedge clk) disable iff (rst)
        (start && !op.legal) |=> ($stable(hi_q) && $stable(lo_q) && !dst_valid));

    // R9: plain accumulate never produces a destination
    p_basic_nodst_r9: assert property (@(posedge clk) disable iff (rst)
        (start && func_code == FN_MULACC && sub_op == 5'b00000) |=> !dst_valid);

    // R11: destination is a sign-extended low word of HI or LO
    p_dst_sext_r11: assert property (@(posedge clk) disable iff (rst)
        dst_valid |-> (dst_data[REGW-1:OPW] == {(REGW-OPW){dst_data[OPW-1]}}));
    p_dst_hilo_r11: assert property (@(posedge clk) disable iff (rst)
        dst_valid |-> (dst_data[OPW-1:0] == hi_q[OPW-1:0] ||
                       dst_data[OPW-1:0] == lo_q[OPW-1:0]));

    // R5..R8: accumulator relation per combine mode
    p_zero_add_r5: assert property (@(posedge clk) disable iff (rst)
        (start && op.legal && op.mode == CMB_ZERO_ADD) |=> acc_view == $past(prod));
    p_zero_sub_r6: assert property (@(posedge clk) disable iff (rst)
        (start && op.legal && op.mode == CMB_ZERO_SUB) |=> (acc_view + $past(prod)) == '0);
    p_acc_add_r7: assert property (@(posedge clk) disable iff (rst)
        (start && op.legal && op.mode == CMB_ACC_ADD) |=>
            acc_view == $past(acc_view) + $past(prod));
    p_acc_sub_r8: assert property (@(posedge clk) disable iff (rst)
        (start && op.legal && op.mode == CMB_ACC_SUB) |=>
            acc_view == $past(acc_view) - $past(prod));

endmodule

// File: tb/mac_hilo_unit_tb.sv
`timescale 1ns/1ps
module mac_hilo_unit_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [5:0]  func_code = '0;
    logic [4:0]  sub_op = '0;
    logic        dst_wr_req = 1'b0;
    logic [63:0] src_a = '0, src_b = '0;
    logic [63:0] hi_q, lo_q, dst_data;
    logic        dst_valid, res_valid;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference state
    logic [63:0] m_hi = '0, m_lo = '0;

    always #2.5 clk = ~clk;

    mac_hilo_unit u_dut (
        .clk(clk), .rst(rst), .start(start), .func_code(func_code),
        .sub_op(sub_op), .dst_wr_req(dst_wr_req), .src_a(src_a),
        .src_b(src_b), .hi_q(hi_q), .lo_q(lo_q), .dst_data(dst_data),
        .dst_valid(dst_valid), .res_valid(res_valid)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Apply one operation, then compare against the reference computed
    // from the requirement text.
    task automatic run_op(input logic [5:0] f, input logic [4:0] s,
                          input logic [63:0] a, input logic [63:0] b,
                          input logic req, input string tag);
        int          kind;          // 0 zadd 1 zsub 2 add 3 sub 4 lo-only
        logic        legal, uns, hih, hasd;
        logic [63:0] p, acc, acc2, exp_dst, ua, ub;
        int          ia, ib;
        longint      la, lb;
        legal = 0; uns = 0; hih = s[3]; hasd = 1; kind = 2;
        if (f == 6'b101000) begin
            uns = s[0];
            if (s == 5'b00000) begin legal = 1; kind = 2; hasd = 0; uns = 0; end
            else if (s inside {5'b00100, 5'b00101, 5'b01100, 5'b01101}) begin legal = 1; kind = 0; end
            else if (s inside {5'b00010, 5'b00011, 5'b01010, 5'b01011}) begin legal = 1; kind = 2; end
        end else if (f == 6'b101001) begin
            if (s == 5'b00000) begin legal = 1; kind = 4; hasd = 0; end
        end else if (f == 6'b011000 || f == 6'b011001) begin
            uns = f[0];
            if (s inside {5'b00011, 5'b01011}) begin legal = 1; kind = 1; end
            else if (s inside {5'b00111, 5'b01111}) begin legal = 1; kind = 3; end
        end
        ia = a[31:0]; ib = b[31:0]; la = ia; lb = ib;
        ua = {32'b0, a[31:0]}; ub = {32'b0, b[31:0]};
        p  = uns ? ua * ub : 64'(la * lb);
        acc = {m_hi[31:0], m_lo[31:0]};
        case (kind)
            0: acc2 = p;
            1: acc2 = 64'd0 - p;
            2: acc2 = acc + p;
            3: acc2 = acc - p;
            default: acc2 = acc;
        endcase
        if (legal) begin
            if (kind == 4) m_lo = m_lo + p;
            else begin
                m_hi = {m_hi[63:32], acc2[63:32]};
                m_lo = {m_lo[63:32], acc2[31:0]};
            end
        end
        exp_dst = hih ? {{32{acc2[63]}}, acc2[63:32]} : {{32{acc2[31]}}, acc2[31:0]};
        @(negedge clk);
        start = 1; func_code = f; sub_op = s; src_a = a; src_b = b; dst_wr_req = req;
        @(negedge clk);
        start = 0; dst_wr_req = 0;
        chk({tag, " R12 res_valid"}, {63'b0, res_valid}, 64'd1);
        chk({tag, " hi"}, hi_q, m_hi);
        chk({tag, " lo"}, lo_q, m_lo);
        chk({tag, " R11 dst_valid"}, {63'b0, dst_valid}, {63'b0, legal && hasd && req});
        if (legal && hasd && req) chk({tag, " R11 dst_data"}, dst_data, exp_dst);
    endtask

    task automatic t_reset();
        chk("R1 hi", hi_q, 0); chk("R1 lo", lo_q, 0); chk("R1 dst", dst_data, 0);
        chk("R1 valids", {62'b0, dst_valid, res_valid}, 0);
    endtask

    task automatic t_clear_add();
        run_op(6'b101000, 5'b00100, 64'hDEADBEEF_FFFFFFFD, 64'h12345678_00000007, 1, "R5 R4 signed lo");
        run_op(6'b101000, 5'b00101, 64'hDEADBEEF_FFFFFFFD, 64'h00000000_00000007, 1, "R5 R4 unsigned lo");
        run_op(6'b101000, 5'b01100, 64'h0_80000000, 64'h0_00000003, 1, "R5 signed hi");
        run_op(6'b101000, 5'b01101, 64'hFFFFFFFF_FFFFFFFF, 64'h0_FFFFFFFF, 1, "R5 R4 unsigned hi");
    endtask

    task automatic t_negate();
        run_op(6'b011000, 5'b00011, 64'd5, 64'd3, 1, "R6 signed lo");
        run_op(6'b011001, 5'b00011, 64'hFFFFFFFF, 64'd2, 1, "R6 unsigned lo");
        run_op(6'b011000, 5'b01011, 64'hFFFFFFF0, 64'd9, 1, "R6 signed hi");
        run_op(6'b011001, 5'b01011, 64'h90000000, 64'h90000000, 1, "R6 unsigned hi");
    endtask

    task automatic t_accumulate();
        run_op(6'b101000, 5'b00100, 64'd1000, 64'd1000, 1, "R7 seed");
        run_op(6'b101000, 5'b00010, 64'hFFFFFFFF, 64'd10, 1, "R7 signed lo");
        run_op(6'b101000, 5'b00011, 64'hFFFFFFFF, 64'd10, 1, "R7 unsigned lo");
        run_op(6'b101000, 5'b01010, 64'h7FFFFFFF, 64'h7FFFFFFF, 1, "R7 signed hi");
        run_op(6'b101000, 5'b01011, 64'hC0000000, 64'h4, 1, "R7 unsigned hi");
    endtask

    task automatic t_subacc();
        run_op(6'b011000, 5'b00111, 64'd7, 64'hFFFFFFFE, 1, "R8 signed lo");
        run_op(6'b011001, 5'b00111, 64'd7, 64'hFFFFFFFE, 1, "R8 unsigned lo");
        run_op(6'b011000, 5'b01111, 64'h12345, 64'h6789A, 1, "R8 signed hi");
        run_op(6'b011001, 5'b01111, 64'hABCDEF01, 64'h2, 1, "R8 unsigned hi");
    endtask

    task automatic t_basic();
        run_op(6'b101000, 5'b00000, 64'hFFFFFFFD, 64'd11, 1, "R9 basic mac");
        run_op(6'b101000, 5'b00000, 64'd3, 64'd4, 1, "R9 basic mac pos");
    endtask

    task automatic t_dword();
        run_op(6'b101001, 5'b00000, 64'hFFFFFFFD, 64'd100, 1, "R10 dword neg");
        run_op(6'b101001, 5'b00000, 64'h40000000, 64'h40000000, 0, "R10 dword pos");
        // LO upper word is now nonzero and must survive a normal write
        run_op(6'b101000, 5'b00100, 64'd2, 64'd3, 1, "R2 upper kept");
        run_op(6'b011000, 5'b01111, 64'd9, 64'd9, 1, "R2 upper kept sub");
    endtask

    task automatic t_wrap();
        run_op(6'b011000, 5'b00011, 64'd1, 64'd1, 1, "R3 set all ones");
        run_op(6'b101000, 5'b00010, 64'd1, 64'd1, 1, "R3 wrap to zero");
        chk("R3 acc zero", {hi_q[31:0], lo_q[31:0]}, 64'd0);
        run_op(6'b011000, 5'b00111, 64'd1, 64'd1, 1, "R3 wrap below zero");
    endtask

    task automatic t_noreq();
        run_op(6'b101000, 5'b01100, 64'd123, 64'd456, 0, "R11 no request");
        run_op(6'b011001, 5'b00011, 64'd8, 64'd8, 0, "R11 no request neg");
    endtask

    task automatic t_idle();
        logic [63:0] h, l;
        run_op(6'b101000, 5'b00100, 64'd77, 64'd2, 1, "R12 op");
        h = hi_q; l = lo_q;
        src_a = 64'd999; src_b = 64'd999; func_code = 6'b101000; sub_op = 5'b00100;
        @(negedge clk);
        chk("R12 res_valid drops", {63'b0, res_valid}, 0);
        chk("R12 dst_valid drops", {63'b0, dst_valid}, 0);
        @(negedge clk);
        chk("R12 hi idle", hi_q, h);
        chk("R12 lo idle", lo_q, l);
    endtask

    task automatic t_illegal();
        run_op(6'b101000, 5'b10100, 64'd5, 64'd5, 1, "R13 bad sub");
        run_op(6'b101010, 5'b00000, 64'd5, 64'd5, 1, "R13 bad func");
        run_op(6'b011000, 5'b00001, 64'd5, 64'd5, 1, "R13 bad neg sub");
        run_op(6'b101001, 5'b00100, 64'd5, 64'd5, 1, "R13 bad dword sub");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 0;
        t_reset();
        t_clear_add();
        t_negate();
        t_accumulate();
        t_subacc();
        t_basic();
        t_dword();
        t_wrap();
        t_noreq();
        t_idle();
        t_illegal();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule